// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

A synchronous binary counter, four bits wide by default, with every state bit updated on the same rising clock edge. One level input picks the direction: low counts up and high counts down. An active-low enable gates counting. An active-low load presets the count from a parallel data input on the next edge, and load wins over counting. Counting wraps modulo 2^WIDTH in both directions.

Two outputs support chaining stages. The terminal flag is a level derived from the present count and direction. It is high at all ones while counting up and at all zeros while counting down. The active-low ripple output pulses low only during the low half of the clock, and only while the terminal flag is high and counting is enabled. A wider counter is built by driving the next stage's enable from the previous stage's terminal flag and enable. All stages then share one clock, and the upper stage advances on the edge where the lower stage wraps.

The count has no functional clear. Software or a sequencer starts the count with a parallel load. An asynchronous reset `rst_ni` is still provided so that the chip has a defined state after power-up.

Top module: `ud_cnt`

## Requirements
- R1: With load_ni high, en_ni low and dir_i low (up), count_o becomes count_o + 1 on the next rising edge.
- R2: With load_ni high, en_ni low and dir_i high (down), count_o becomes count_o - 1 on the next rising edge.
- R3: With load_ni high and en_ni high, count_o holds its value on the next rising edge whatever dir_i is.
- R4: With load_ni low, count_o takes data_i on the next rising edge, whatever en_ni and dir_i are (load has priority over counting).
- R5: Counting wraps: all ones counting up goes to zero, and zero counting down goes to all ones.
- R6: max_min_o is high exactly when count_o is all ones with dir_i low, or all zeros with dir_i high; it does not depend on en_ni.
- R7: ripple_no is low only while clk_i is low, max_min_o is high and en_ni is low; otherwise it is high.
- R8: While rst_ni is low, count_o is zero without waiting for a clock edge.
- R9: When two stages share the clock and the upper stage's en_ni is the inverse of (lower max_min_o AND NOT lower en_ni), the pair counts as one 2*WIDTH-bit counter, carrying at all ones going up and borrowing at zero going down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; count changes on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears the count |
| dir_i | input | 1 | Direction: 0 counts up, 1 counts down |
| en_ni | input | 1 | Active-low count enable |
| load_ni | input | 1 | Active-low synchronous parallel load |
| data_i | input | WIDTH | Parallel load value |
| count_o | output | WIDTH | Present count |
| max_min_o | output | 1 | Terminal-count flag for the present direction |
| ripple_no | output | 1 | Active-low cascade pulse in the low clock phase |

## Verification
The bench builds two instances with the default WIDTH of 4 and chains them through the terminal flag into an 8-bit counter. With only 16 states per stage, full sweeps up and down are short. These sweeps reach every wrap of the lower stage, the 8-bit carry at 255 and the borrow at 0. Loads placed right next to those boundaries test load priority against a live carry. The ripple output is checked in both clock phases, with counting enabled and with counting disabled while the flag is high.

// File: rtl/ud_cnt_pkg.sv
package ud_cnt_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/ud_cnt_next.sv
module ud_cnt_next #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             dir_i,
  input  logic             en_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] nxt_o
);
  import ud_cnt_pkg::*;

  localparam logic [WIDTH-1:0] Step = WIDTH'(1);

  dir_e             dir;
  logic [WIDTH-1:0] stepped;

  assign dir = dir_e'(dir_i);

  // modulo-2^WIDTH step, wrap falls out of the fixed width
  always_comb begin
    if (dir == DIR_UP) stepped = cur_i + Step;
    else               stepped = cur_i - Step;
  end

  always_comb begin
    if (!load_ni)      nxt_o = data_i;
    else if (!en_ni)   nxt_o = stepped;
    else               nxt_o = cur_i;
  end
endmodule

// File: rtl/ud_cnt_term.sv
module ud_cnt_term #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] cur_i,
  input  logic             dir_i,
  input  logic             en_ni,
  output logic             max_min_o,
  output logic             ripple_no
);
  import ud_cnt_pkg::*;

  logic at_top;
  logic at_bottom;

  assign at_top    = &cur_i;
  assign at_bottom = ~|cur_i;

  assign max_min_o = (dir_e'(dir_i) == DIR_UP) ? at_top : at_bottom;

  // pulse confined to the low clock phase
  assign ripple_no = ~(max_min_o & ~en_ni & ~clk_i);
endmodule

// File: rtl/ud_cnt.sv
module ud_cnt #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_i,
  input  logic             en_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             max_min_o,
  output logic             ripple_no
);
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  ud_cnt_next #(.WIDTH(WIDTH)) u_next (
    .cur_i   (cnt_q),
    .dir_i   (dir_i),
    .en_ni   (en_ni),
    .load_ni (load_ni),
    .data_i  (data_i),
    .nxt_o   (cnt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  ud_cnt_term #(.WIDTH(WIDTH)) u_term (
    .clk_i     (clk_i),
    .cur_i     (cnt_q),
    .dir_i     (dir_i),
    .en_ni     (en_ni),
    .max_min_o (max_min_o),
    .ripple_no (ripple_no)
  );

  assign count_o = cnt_q;
endmodule

// File: rtl/ud_cnt_chk.sv
module ud_cnt_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dir_i,
  input logic             en_ni,
  input logic             load_ni,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] count_o,
  input logic             max_min_o,
  input logic             ripple_no
);
  localparam logic [WIDTH-1:0] One = WIDTH'(1);

  // R1, R5
  a_r1_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_ni && !dir_i) |=> (count_o == $past(count_o) + One));

  // R2, R5
  a_r2_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_ni && dir_i) |=> (count_o == $past(count_o) - One));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && en_ni) |=> $stable(count_o));

  a_r4_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> (count_o == $past(data_i)));

  a_r6_flag_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    max_min_o |-> ((&count_o) || (~|count_o)));

  // sampled just before the falling edge, clock still high
  a_r7_high_phase: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ripple_no);

  a_r7_disabled_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |-> ripple_no);
endmodule

bind ud_cnt ud_cnt_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dir_i     (dir_i),
  .en_ni     (en_ni),
  .load_ni   (load_ni),
  .data_i    (data_i),
  .count_o   (count_o),
  .max_min_o (max_min_o),
  .ripple_no (ripple_no)
);

// File: tb/tb_ud_cnt.sv
module tb_ud_cnt;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  localparam int OP_UP   = 0;
  localparam int OP_DN   = 1;
  localparam int OP_HOLD = 2;
  localparam int OP_LOAD = 3;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         dir_i = 1'b0;
  logic         en_ni = 1'b1;
  logic         load_ni = 1'b1;
  logic [7:0]   data = 8'h00;
  logic [W-1:0] cnt_lo, cnt_hi;
  logic         mm_lo, mm_hi, rip_lo, rip_hi;
  logic         hi_en_n;

  int checks = 0;
  int errors = 0;
  logic [7:0] model = 8'h00;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  assign hi_en_n = ~(mm_lo & ~en_ni);

  ud_cnt #(.WIDTH(W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .dir_i(dir_i), .en_ni(en_ni),
    .load_ni(load_ni), .data_i(data[3:0]), .count_o(cnt_lo),
    .max_min_o(mm_lo), .ripple_no(rip_lo)
  );

  ud_cnt #(.WIDTH(W)) u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .dir_i(dir_i), .en_ni(hi_en_n),
    .load_ni(load_ni), .data_i(data[7:4]), .count_o(cnt_hi),
    .max_min_o(mm_hi), .ripple_no(rip_hi)
  );

  function automatic logic term(input logic [3:0] v, input logic d);
    return d ? (v == 4'h0) : (v == 4'hF);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, push the expected count
  task automatic step(input int op, input logic [7:0] val);
    @(negedge clk_i);
    load_ni = (op != OP_LOAD);
    en_ni   = (op == OP_HOLD);
    dir_i   = (op == OP_DN);
    data    = val;
    #1;
    // R7: low phase, pulse only when flag high and enabled
    check("R7 ripple low phase", rip_lo,
          !(term(model[3:0], dir_i) && !en_ni));
    case (op)
      OP_UP:   model = model + 8'd1;
      OP_DN:   model = model - 8'd1;
      OP_LOAD: model = val;
      default: model = model;
    endcase
    exp_q.push_back(model);
  endtask

  // monitor: compare after each edge, in the high clock phase
  initial begin
    forever begin
      @(posedge clk_i);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check("R1/R2/R3/R4/R5/R9 count", {cnt_hi, cnt_lo}, e);
        check("R6 max_min lo", mm_lo, term(e[3:0], dir_i));
        check("R9 max_min hi", mm_hi, term(e[7:4], dir_i));
        check("R7 ripple high phase", rip_lo, 1);
      end
    end
  end

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 2);
    check("R8 reset lo", cnt_lo, 0);
    check("R8 reset hi", cnt_hi, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R4 load, R1 count up across the 8-bit carry (R5, R9)
    step(OP_LOAD, 8'hFE);
    repeat (4) step(OP_UP, 8'h00);
    // R3 hold, including hold at a terminal value
    step(OP_LOAD, 8'h0F);
    repeat (3) step(OP_HOLD, 8'h00);
    step(OP_UP, 8'h00);
    // R2 down across the borrow at zero
    step(OP_LOAD, 8'h02);
    repeat (5) step(OP_DN, 8'h00);
    // R4 load wins at a point where counting would carry
    step(OP_LOAD, 8'hFF);
    step(OP_LOAD, 8'h5A);
    step(OP_DN, 8'h00);
    step(OP_LOAD, 8'h10);
    step(OP_DN, 8'h00);
    // full sweeps
    step(OP_LOAD, 8'h00);
    repeat (300) step(OP_UP, 8'h00);
    repeat (300) step(OP_DN, 8'h00);

    // R8 reset mid-run, asynchronous
    step(OP_LOAD, 8'hC3);
    @(negedge clk_i);
    load_ni = 1'b1; en_ni = 1'b1;
    #1;
    rst_ni = 1'b0;
    #1;
    check("R8 async clear lo", cnt_lo, 0);
    check("R8 async clear hi", cnt_hi, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    model = 8'h00;
    repeat (20) step(OP_DN, 8'h00);

    @(negedge clk_i);
    @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule